// File: doc/BRIEF.md
# Preloaded Up-Counting Timer

This block is a general-purpose timer whose counter climbs from zero to a reload limit and then wraps. A prescaler in front of it divides the clock, so the counter advances once every (divide value + 1) clocks while counting is enabled. Software writes the divide value and the reload limit into preload registers. Neither value reaches the counting logic until an update event copies both preloads into working (shadow) copies. An update event happens at every wrap, or when software writes a one-shot update strobe.

Two control bits decide what an update does. The inhibit bit suppresses update events altogether. Even then, the software strobe still restarts both counters. The quiet-strobe bit lets the software strobe reload the shadows without raising the update flag. The update flag drives an interrupt request when its enable bit is set. Access goes through a simple strobed register interface, and every read returns its data one clock after the read strobe.

Top module: `upcnt_timer`

## Requirements
- R1: After reset, every register reads 0, except that the reload preload reads all ones. The irq output is 0 and counting is off. Register addresses: 0 control (bit0 count enable, bit1 update inhibit, bit2 quiet strobe, bit3 interrupt enable), 1 status (bit0 update flag), 2 update strobe (bit0), 3 counter (read only), 4 divide preload, 5 reload preload. Read data appears on rdata one clock after rd_en.
- R2: On each counter step, the counter goes from the active reload limit to 0, and that step is an overflow. Unless inhibited, an overflow is an update event and sets the update flag.
- R3: The counter advances once per (active divide value + 1) enabled clocks, and it holds its value while count enable is 0.
- R4: Written divide and reload values have no effect on counting until an update event. Reading either register returns the value written, not the active value.
- R5: Writing 1 to strobe bit0 causes an update event. The event copies both preloads into the active values, restarts the counter and the prescaler at 0, and sets the update flag. The strobe register always reads 0.
- R6: While update inhibit is 1, neither an overflow nor the strobe changes the active divide or reload value or sets the flag. The strobe still restarts the counter and the prescaler at 0.
- R7: While quiet strobe is 1, the software strobe reloads the active values and restarts the counters, but it leaves the flag clear. An overflow still sets the flag.
- R8: Writing status with bit0 = 0 clears the flag. If a flag set and a clear fall on the same clock, the flag stays set.
- R9: irq equals (update flag AND interrupt enable), registered one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with an 8-bit counter and an 8-bit prescaler inside a 32-bit data path. With these widths the all-ones reset limit reads back as 0xFF, which shows the zero extension on the read path. Reload limits of 4 and 9 and a divide of 3 keep every wrap within tens of cycles. That leaves room to land a flag clear on the exact clock of an overflow, and to tell apart the counts that stale and freshly loaded shadow values would give.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int A_CTRL   = 0;
  localparam int A_STATUS = 1;
  localparam int A_STROBE = 2;
  localparam int A_COUNT  = 3;
  localparam int A_DIV    = 4;
  localparam int A_LIMIT  = 5;

  typedef struct packed {
    logic ie;
    logic quiet;
    logic inhibit;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  div_pre,
  output logic [CNT_W-1:0]  lim_pre,
  output logic              strobe,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);

  logic sel_ctrl, sel_stat, sel_strb, sel_div, sel_lim;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  assign sel_ctrl = (addr == ADDR_W'(A_CTRL));
  assign sel_stat = (addr == ADDR_W'(A_STATUS));
  assign sel_strb = (addr == ADDR_W'(A_STROBE));
  assign sel_div  = (addr == ADDR_W'(A_DIV));
  assign sel_lim  = (addr == ADDR_W'(A_LIMIT));

  assign strobe   = wr_en && sel_strb && wdata[0];
  assign flag_clr = wr_en && sel_stat && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      div_pre <= '0;
      lim_pre <= '1;
    end else if (wr_en) begin
      if (sel_ctrl) ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (sel_div)  div_pre <= wdata[PSC_W-1:0];
      if (sel_lim)  lim_pre <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(addr))
      A_CTRL:   rd_mux = DATA_W'(ctrl);
      A_STATUS: rd_mux = DATA_W'(flag);
      A_COUNT:  rd_mux = DATA_W'(cnt);
      A_DIV:    rd_mux = DATA_W'(div_pre);
      A_LIMIT:  rd_mux = DATA_W'(lim_pre);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             uev,
  input  logic [PSC_W-1:0] div_pre,
  output logic [PSC_W-1:0] div_act,
  output logic [PSC_W-1:0] psc_cnt,
  output logic             tick
);

  logic at_end;

  assign at_end = (psc_cnt == div_act);
  assign tick   = en && !restart && at_end;

  always_ff @(posedge clk) begin
    if (rst)          psc_cnt <= '0;
    else if (restart) psc_cnt <= '0;
    else if (en)      psc_cnt <= at_end ? '0 : psc_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      div_act <= '0;
    else if (uev) div_act <= div_pre;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             uev,
  input  logic [CNT_W-1:0] lim_pre,
  output logic [CNT_W-1:0] lim_act,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  assign ovf = tick && (cnt == lim_act);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= ovf ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)      lim_act <= '1;
    else if (uev) lim_act <= lim_pre;
  end

endmodule

// File: rtl/tmr_update.sv
module tmr_update (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic strobe,
  input  logic inhibit,
  input  logic quiet,
  input  logic ie,
  input  logic flag_clr,
  output logic uev,
  output logic restart,
  output logic flag,
  output logic irq
);

  logic flag_set;

  assign uev      = !inhibit && (ovf || strobe);
  assign restart  = strobe;
  assign flag_set = !inhibit && (ovf || (strobe && !quiet));

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (flag_set) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag && ie;
  end

endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  ctrl_t            ctrl;
  logic [PSC_W-1:0] div_pre, div_act, psc_cnt;
  logic [CNT_W-1:0] lim_pre, lim_act, cnt;
  logic             strobe, flag_clr, flag, tick, ovf, uev, restart;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .flag(flag), .ctrl(ctrl), .div_pre(div_pre), .lim_pre(lim_pre),
    .strobe(strobe), .flag_clr(flag_clr), .rdata(rdata)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .en(ctrl.en), .restart(restart), .uev(uev),
    .div_pre(div_pre), .div_act(div_act), .psc_cnt(psc_cnt), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .uev(uev),
    .lim_pre(lim_pre), .lim_act(lim_act), .cnt(cnt), .ovf(ovf)
  );

  tmr_update u_upd (
    .clk(clk), .rst(rst), .ovf(ovf), .strobe(strobe), .inhibit(ctrl.inhibit),
    .quiet(ctrl.quiet), .ie(ctrl.ie), .flag_clr(flag_clr), .uev(uev),
    .restart(restart), .flag(flag), .irq(irq)
  );

endmodule

// File: rtl/upcnt_timer_chk.sv
module upcnt_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             flag_clr,
  input logic             ovf,
  input logic             inhibit,
  input logic             quiet,
  input logic             ie,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim_act,
  input logic [PSC_W-1:0] psc_cnt,
  input logic [PSC_W-1:0] div_act
);

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt <= lim_act)); // R2

  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (cnt == '0) && (psc_cnt == '0)); // R5

  AST_INHIBIT_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> $stable(lim_act) && $stable(div_act)); // R6

  AST_INHIBIT_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !flag) |=> !flag); // R6

  AST_QUIET_STROBE: assert property (@(posedge clk) disable iff (rst)
    (strobe && quiet && !flag && !ovf) |=> !flag); // R7

  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ovf) |=> !flag); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && ovf && !inhibit) |=> flag); // R8

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(flag && ie))); // R9

endmodule

bind upcnt_timer upcnt_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .flag_clr(flag_clr), .ovf(ovf),
  .inhibit(ctrl.inhibit), .quiet(ctrl.quiet), .ie(ctrl.ie), .flag(flag),
  .irq(irq), .cnt(cnt), .lim_act(lim_act), .psc_cnt(psc_cnt), .div_act(div_act)
);

// File: tb/upcnt_timer_tb.sv
module upcnt_timer_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  ev;

  always #4 clk = ~clk;

  upcnt_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // monitor: pops expected items and compares against the ports
  always begin
    @(ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    item_t it;
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> ev;
    #0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, exp}; it.tag = tag;
    q.push_back(it);
    -> ev;
    #0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(0, 32'h0,  "R1 ctrl");
    rd(1, 32'h0,  "R1 status");
    rd(3, 32'h0,  "R1 count");
    rd(4, 32'h0,  "R1 divide");
    rd(5, 32'hFF, "R1 limit");
    chk_irq(1'b0, "R1 irq");

    // R4 limit preload not yet active: counter passes 9
    wr(5, 9);
    wr(0, 1);
    idle(14);
    wr(0, 0);
    rd(3, 15, "R4 count past preload");
    rd(5, 9,  "R4 limit readback");

    // R5 strobe loads shadows, restarts, flags
    wr(2, 1);
    rd(3, 0, "R5 count restart");
    rd(1, 1, "R5 flag set");
    rd(2, 0, "R5 strobe reads 0");

    // R2 wrap at limit 9 sets flag
    wr(1, 0);
    rd(1, 0, "R8 flag cleared");
    wr(0, 1);
    idle(9);
    wr(0, 0);
    rd(3, 0, "R2 wrap to 0");
    rd(1, 1, "R2 flag on overflow");

    // R3 divide by 3
    wr(4, 2);
    wr(2, 1);
    wr(1, 0);
    wr(0, 1);
    idle(8);
    wr(0, 0);
    rd(3, 3, "R3 divided count");
    idle(5);
    rd(3, 3, "R3 hold while disabled");

    // R6 inhibit
    wr(0, 2);
    wr(4, 0);
    wr(5, 4);
    wr(2, 1);
    rd(3, 0, "R6 strobe restarts");
    rd(1, 0, "R6 no flag on strobe");
    wr(0, 3);
    idle(23);
    wr(0, 2);
    rd(3, 8, "R6 shadows unchanged");
    wr(0, 3);
    idle(5);
    wr(0, 2);
    rd(3, 0, "R6 wrap while inhibited");
    rd(1, 0, "R6 no flag on overflow");
    rd(4, 0, "R4 divide readback");

    // R7 quiet strobe
    wr(0, 4);
    wr(2, 1);
    rd(1, 0, "R7 quiet strobe no flag");
    wr(0, 5);
    idle(4);
    wr(0, 4);
    rd(3, 0, "R7 new limit 4 active");
    rd(1, 1, "R7 overflow still flags");

    // R9 interrupt
    chk_irq(1'b0, "R9 irq masked");
    wr(0, 8);
    idle(1);
    chk_irq(1'b1, "R9 irq raised");
    wr(1, 0);
    idle(1);
    chk_irq(1'b0, "R9 irq dropped");
    rd(1, 0, "R8 clear");

    // R8 set wins over clear on same clock
    wr(0, 9);
    idle(4);
    wr(1, 0);
    wr(0, 8);
    rd(1, 1, "R8 set wins");
    rd(3, 1, "R8 count after wrap");
    chk_irq(1'b1, "R9 irq after set");

    idle(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule